// File: doc/BRIEF.md
# Program Counter Sequencing Unit

This unit owns the program counter and the instruction-set state bit of a processor that runs either 32-bit wide instructions or 16-bit compact instructions. On every cycle in which the step strobe is high, it picks the next fetch address. For in-line execution, it adds the instruction size of the current state to the PC. For a taken branch, it loads the target address. Branches that carry a link also present a return address and a write enable for the link register. Branches that carry an exchange take the new instruction-set state from bit 0 of the target.

Decode and condition evaluation sit upstream and deliver a branch-kind code and a target together with the strobe. Exception redirection is handled elsewhere. The step interface is a plain strobe with no ready signal. The unit has no back-pressure: it accepts a step on every cycle, and the upstream stage must hold the strobe low on any cycle it wants the PC to stay put.

The PC and the state bit are registered and take their new values at the clock edge that ends a strobed cycle. The link value and its write enable are combinational in the strobed cycle, so the register file can capture them at that same edge.

Top module: `pcseq_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `pc_q` to 0 and clears `compact_q`, which selects the 32-bit state. While reset is active, `lnk_we` is low.
- R2: With `compact_q` = 0, a strobed step of kind 0 (sequential) advances `pc_q` by 4 and keeps the state.
- R3: With `compact_q` = 1, a strobed step of kind 0 advances `pc_q` by 2 and keeps the state.
- R4: Kind 1 (plain branch) loads `br_target` unchanged into `pc_q`, keeps `compact_q`, and holds `lnk_we` low.
- R5: Kind 2 (branch with link) loads `br_target` unchanged into `pc_q`, keeps `compact_q`, and raises `lnk_we` in that cycle.
- R6: Kind 3 (branch with exchange) sets `compact_q` to `br_target[0]` and loads the target into `pc_q` with bit 0 cleared. When the new state is 32-bit, bit 1 is cleared as well. `lnk_we` stays low.
- R7: Kind 4 (branch with link and exchange) updates `pc_q` and `compact_q` exactly as in R6 and also raises `lnk_we`.
- R8: The link value `lnk_val` is the current `pc_q` plus 4 in the 32-bit state. In the compact state it is the current `pc_q` plus 2, with bit 0 forced to 1.
- R9: While `step_valid` is low, `pc_q` and `compact_q` hold their values and `lnk_we` stays low, whatever `br_kind` holds.
- R10: The unused kind codes 5 to 7 behave as a sequential step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_valid | input | 1 | Strobe: this cycle carries a step |
| br_kind | input | 3 | Step kind: 0 sequential, 1 branch, 2 link, 3 exchange, 4 link+exchange |
| br_target | input | AW (32) | Branch target address |
| pc_q | output | AW (32) | Current program counter |
| compact_q | output | 1 | Instruction-set state: 1 = 16-bit compact |
| lnk_we | output | 1 | Link register write enable, valid in the strobed cycle |
| lnk_val | output | AW (32) | Return address to write into the link register |

## Verification
The bench checks each way the step size can depend on the state. A unit that always adds 4 goes wrong as soon as an exchange enters the compact state. The bench also checks link values taken in both states. A design that forgets to set bit 0 in the compact state would return into the wrong state.

Exchange targets are chosen with bit 1 set and bit 0 clear. A missing bit-1 mask would then leave a misaligned 32-bit PC, and a state taken from the wrong bit would flip the mode. The bench also drives a link kind with the strobe low, which catches a write enable that is not gated. Finally it exercises an unused kind code and a reset in the middle of a run.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [2:0] {
    KIND_SEQ  = 3'd0,
    KIND_JMP  = 3'd1,
    KIND_LNK  = 3'd2,
    KIND_XCH  = 3'd3,
    KIND_LXCH = 3'd4
  } br_kind_t;

  localparam int unsigned WIDE_STEP    = 4;
  localparam int unsigned COMPACT_STEP = 2;
endpackage

// File: rtl/pcseq_incr.sv
module pcseq_incr #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] pc,
  input  logic          compact,
  output logic [AW-1:0] sum
);
  import pcseq_pkg::*;
  localparam logic [AW-1:0] WSTEP = AW'(WIDE_STEP);
  localparam logic [AW-1:0] CSTEP = AW'(COMPACT_STEP);

  assign sum = pc + (compact ? CSTEP : WSTEP);
endmodule

// File: rtl/pcseq_link.sv
module pcseq_link #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] ret_addr,
  input  logic          compact,
  output logic [AW-1:0] link
);
  assign link = {ret_addr[AW-1:1], ret_addr[0] | compact};
endmodule

// File: rtl/pcseq_xchg.sv
module pcseq_xchg #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] target,
  output logic [AW-1:0] aligned,
  output logic          to_compact
);
  assign to_compact = target[0];
  assign aligned    = {target[AW-1:2], target[1] & target[0], 1'b0};
endmodule

// File: rtl/pcseq_unit.sv
module pcseq_unit #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_valid,
  input  logic [2:0]    br_kind,
  input  logic [AW-1:0] br_target,
  output logic [AW-1:0] pc_q,
  output logic          compact_q,
  output logic          lnk_we,
  output logic [AW-1:0] lnk_val
);
  import pcseq_pkg::*;

  logic [AW-1:0] seq_pc;
  logic [AW-1:0] xch_pc;
  logic          xch_state;
  logic [AW-1:0] pc_d;
  logic          compact_d;
  logic          is_link;

  pcseq_incr #(.AW(AW)) u_incr (
    .pc      (pc_q),
    .compact (compact_q),
    .sum     (seq_pc)
  );

  pcseq_link #(.AW(AW)) u_link (
    .ret_addr (seq_pc),
    .compact  (compact_q),
    .link     (lnk_val)
  );

  pcseq_xchg #(.AW(AW)) u_xchg (
    .target     (br_target),
    .aligned    (xch_pc),
    .to_compact (xch_state)
  );

  always_comb begin
    pc_d      = seq_pc;
    compact_d = compact_q;
    is_link   = 1'b0;
    case (br_kind)
      KIND_JMP:  pc_d = br_target;
      KIND_LNK: begin
        pc_d    = br_target;
        is_link = 1'b1;
      end
      KIND_XCH: begin
        pc_d      = xch_pc;
        compact_d = xch_state;
      end
      KIND_LXCH: begin
        pc_d      = xch_pc;
        compact_d = xch_state;
        is_link   = 1'b1;
      end
      default: pc_d = seq_pc;
    endcase
  end

  assign lnk_we = step_valid && is_link && !rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q      <= '0;
      compact_q <= 1'b0;
    end else if (step_valid) begin
      pc_q      <= pc_d;
      compact_q <= compact_d;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !step_valid |=> $stable(pc_q) && $stable(compact_q)); // R9
  AST_LINK_NEEDS_STEP: assert property (@(posedge clk) disable iff (rst)
    lnk_we |-> step_valid); // R9
  AST_XCHG_ALIGN: assert property (@(posedge clk) disable iff (rst)
    step_valid && (br_kind == KIND_XCH || br_kind == KIND_LXCH)
      |=> !pc_q[0] && (compact_q || !pc_q[1])); // R6
  AST_XCHG_STATE: assert property (@(posedge clk) disable iff (rst)
    step_valid && (br_kind == KIND_XCH || br_kind == KIND_LXCH)
      |=> compact_q == $past(br_target[0])); // R7
  AST_JMP_NO_LINK: assert property (@(posedge clk) disable iff (rst)
    step_valid && br_kind == KIND_JMP |-> !lnk_we); // R4
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    step_valid && br_kind == KIND_SEQ
      |=> pc_q == $past(pc_q) + ($past(compact_q) ? AW'(2) : AW'(4))); // R2
  AST_LINK_TAG: assert property (@(posedge clk) disable iff (rst)
    lnk_we && compact_q |-> lnk_val[0]); // R8
endmodule

// File: tb/tb_pcseq_unit.sv
module tb_pcseq_unit;
  localparam int unsigned AW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          step_valid;
  logic [2:0]    br_kind;
  logic [AW-1:0] br_target;
  logic [AW-1:0] pc_q;
  logic          compact_q;
  logic          lnk_we;
  logic [AW-1:0] lnk_val;

  int total = 0;
  int bad   = 0;

  logic [AW-1:0] exp_pc;
  logic          exp_cmp;

  always #2 clk = ~clk;

  pcseq_unit #(.AW(AW)) dut (
    .clk(clk), .rst(rst), .step_valid(step_valid), .br_kind(br_kind),
    .br_target(br_target), .pc_q(pc_q), .compact_q(compact_q),
    .lnk_we(lnk_we), .lnk_val(lnk_val)
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One strobed step; expected values follow the requirements.
  task automatic step(input string req, input logic [2:0] kind, input logic [AW-1:0] tgt);
    logic          lk;
    logic          xc;
    logic [AW-1:0] ret;
    @(negedge clk);
    step_valid = 1'b1;
    br_kind    = kind;
    br_target  = tgt;
    #1;
    lk  = (kind == 3'd2) || (kind == 3'd4);
    xc  = (kind == 3'd3) || (kind == 3'd4);
    ret = exp_pc + (exp_cmp ? 32'd2 : 32'd4);
    if (exp_cmp) ret[0] = 1'b1;
    chk({req, " link-enable"}, {31'd0, lnk_we}, {31'd0, lk});
    if (lk) chk({req, " R8 link-value"}, lnk_val, ret);
    if (kind == 3'd1 || kind == 3'd2) exp_pc = tgt;
    else if (xc) begin
      exp_cmp = tgt[0];
      exp_pc  = tgt & ~32'd1;
      if (!tgt[0]) exp_pc[1] = 1'b0;
    end else exp_pc = exp_pc + (exp_cmp ? 32'd2 : 32'd4);
    @(negedge clk);
    step_valid = 1'b0;
    chk({req, " pc"}, pc_q, exp_pc);
    chk({req, " state"}, {31'd0, compact_q}, {31'd0, exp_cmp});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    step_valid = 1'b1;
    br_kind = 3'd2;
    #1;
    chk("R1 link-enable in reset", {31'd0, lnk_we}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    step_valid = 1'b0;
    exp_pc = '0;
    exp_cmp = 1'b0;
    chk("R1 pc", pc_q, 32'd0);
    chk("R1 state", {31'd0, compact_q}, 32'd0);
  endtask

  task automatic test_wide_seq();
    for (int i = 0; i < 3; i++) step("R2 wide seq", 3'd0, '0);
  endtask

  task automatic test_branches_wide();
    step("R4 plain", 3'd1, 32'h0000_0100);
    step("R5 link wide", 3'd2, 32'h0000_0200);
  endtask

  task automatic test_enter_compact();
    step("R6 exch to compact", 3'd3, 32'h0000_0301);
    step("R3 compact seq", 3'd0, '0);
    step("R3 compact seq", 3'd0, '0);
    step("R5 link compact", 3'd2, 32'h0000_0400);
  endtask

  task automatic test_idle();
    @(negedge clk);
    step_valid = 1'b0;
    br_kind = 3'd4;
    br_target = 32'h0000_0999;
    #1;
    chk("R9 idle link-enable", {31'd0, lnk_we}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R9 idle pc", pc_q, exp_pc);
    chk("R9 idle state", {31'd0, compact_q}, {31'd0, exp_cmp});
  endtask

  task automatic test_link_exchange();
    step("R7 lx to wide", 3'd4, 32'h0000_0502);
    step("R7 lx to compact", 3'd4, 32'h0000_0611);
    step("R6 exch stay compact", 3'd3, 32'h0000_0703);
    step("R6 exch to wide mask", 3'd3, 32'h0000_0706);
  endtask

  task automatic test_unused_codes();
    step("R10 code5", 3'd5, 32'h0000_1234);
    step("R10 code7", 3'd7, 32'h0000_1235);
    step("R4 plain from wide", 3'd1, 32'h0000_0801);
    step("R6 exch compact", 3'd3, 32'h0000_0A01);
    step("R10 code6 compact", 3'd6, 32'h0000_0F00);
  endtask

  initial begin
    rst = 1'b1;
    step_valid = 1'b0;
    br_kind = 3'd0;
    br_target = '0;
    exp_pc = '0;
    exp_cmp = 1'b0;
    repeat (2) @(negedge clk);
    do_reset();
    test_wide_seq();
    test_branches_wide();
    test_enter_compact();
    test_idle();
    test_link_exchange();
    test_unused_codes();
    do_reset();
    step("R2 seq after reset", 3'd0, '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #20000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule